// File: doc/BRIEF.md
# Life-Cycle Return-Merchandise Zeroization Sequencer

This block keeps the life-cycle state of a secure engine and runs the irreversible retirement path. The path needs two resets. First, software programs a one-time flag into a small set-only configuration word. After the next power-on reset the boot step samples that word, and the return-for-repair service then becomes available. Software may now issue a single request, which marks a sticky pending bit in the same word and moves the reported state to pending. After a second power-on reset the boot step sees the pending bit. It then clears every word of the internal key bank, one word per cycle, and parks the engine in the terminal state, where it never serves again.

Downstream logic uses the `operable` output to block service. The life-cycle state can be read at all times. The set-only word and the key bank keep their contents across power-on reset. Only the blank-array reset clears them, and that reset stands for a factory-fresh part. The service port reads key words back while the engine is operable. In every other state it returns an error with zero data.

Top module: `lcs_rma_sequencer`

## Requirements
- R1: While `porRstN` is low, `lcState` reads 2'b00 (booting), and `operable`, `rmaAvail`, `rmaRejected`, `zeroDone` and `svcAck` are all 0.
- R2: The configuration word `otpWord` only ever gains bits. A write ORs `otpWrData` into it. A write never sets bit 1 (the pending bit). No write and no power-on reset clears a set bit.
- R3: On the first clock edge after `porRstN` rises, if bit 1 of `otpWord` is clear, `lcState` becomes 2'b01 (secure), `operable` becomes 1, and `rmaAvail` takes the value of bit 0 (the repair flag) as sampled at that edge. Later writes do not change `rmaAvail` until the next boot.
- R4: A `rmaReq` seen at an edge while the state is secure and `rmaAvail` is 1 moves `lcState` to 2'b10 (pending) and sets bit 1 of `otpWord` at that edge. `operable` stays 1.
- R5: Any `rmaReq` that R4 does not accept leaves `lcState` unchanged and sets `rmaRejected`. `rmaRejected` stays set until the next power-on reset.
- R6: On the first edge after `porRstN` rises with bit 1 set, `lcState` becomes 2'b11 (rma) and `operable` stays 0. Key words 0 to NUM_KEYS-1 are then cleared one per edge. `zeroDone` rises at the edge NUM_KEYS edges after the state turned rma, and by then every key word is zero.
- R7: While `operable` is 1, `svcReq` at an edge gives `svcAck`=1, `svcErr`=0 and `svcData` equal to key word `svcIdx` after that edge. `keyWrEn` at an edge stores `keyWrData` into word `keyWrIdx`.
- R8: While `operable` is 0, `svcReq` gives `svcAck`=1, `svcErr`=1 and `svcData`=0 after the edge, and `keyWrEn` is ignored.
- R9: Key words and `otpWord` keep their values across a power-on reset that does not lead to zeroization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, asynchronous, active low |
| blankRstN | input | 1 | Blank-array reset for the set-only word and key bank, active low |
| otpWrEn | input | 1 | Strobe that ORs otpWrData into the set-only word |
| otpWrData | input | OTP_W | Bits to set (the pending bit is masked) |
| otpWord | output | OTP_W | Current set-only word |
| rmaReq | input | 1 | Return-for-repair request, one cycle |
| keyWrEn | input | 1 | Key word write strobe |
| keyWrIdx | input | IDX_W | Key word index for writes |
| keyWrData | input | KEY_W | Key word write data |
| svcReq | input | 1 | Service read request |
| svcIdx | input | IDX_W | Key word index for service reads |
| svcAck | output | 1 | Service response valid |
| svcErr | output | 1 | Service response is an error |
| svcData | output | KEY_W | Service response data, zero on error |
| lcState | output | 2 | Life-cycle state: 00 boot, 01 secure, 10 pending, 11 rma |
| rmaAvail | output | 1 | Repair request may be accepted in this boot |
| rmaRejected | output | 1 | Sticky: a repair request was refused |
| operable | output | 1 | Service allowed |
| zeroDone | output | 1 | Key bank zeroization finished |

## Verification
The hardest condition to reach is the zeroization boot. It takes a flag write, a reset, an accepted request and a second reset, in that order, and both the key bank and the configuration word must survive the first reset. The stimulus fills every key word with a computed pattern in the first boot. It then shows that those words and the flag come back intact after one reset. Next it walks the request through the rejected and accepted cases. Last it counts edges after the final reset to catch `zeroDone` exactly at its cycle, and then probes the service and write ports in the terminal state.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

  typedef enum logic [1:0] {
    LC_BOOT   = 2'b00,
    LC_SECURE = 2'b01,
    LC_PEND   = 2'b10,
    LC_RMA    = 2'b11
  } lcState_t;

  typedef enum logic [1:0] {
    FSM_BOOT = 2'b00,
    FSM_RUN  = 2'b01,
    FSM_ZERO = 2'b10,
    FSM_DEAD = 2'b11
  } seqFsm_t;

  // strobes from control to datapath; index field sized for the widest bank
  typedef struct packed {
    logic       setPending;
    logic       clrEn;
    logic [7:0] clrIdx;
    logic       grant;
  } ctrlStrobe_t;

endpackage

// File: rtl/lcs_datapath.sv
module lcs_datapath
  import lcs_pkg::*;
#(
  parameter int KEY_W    = 32,
  parameter int NUM_KEYS = 8,
  parameter int OTP_W    = 8,
  parameter int PEND_BIT = 1,
  localparam int IDX_W   = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic             clk,
  input  logic             porRstN,
  input  logic             blankRstN,
  input  ctrlStrobe_t      strobe,
  input  logic             otpWrEn,
  input  logic [OTP_W-1:0] otpWrData,
  output logic [OTP_W-1:0] otpWord,
  input  logic             keyWrEn,
  input  logic [IDX_W-1:0] keyWrIdx,
  input  logic [KEY_W-1:0] keyWrData,
  input  logic             svcReq,
  input  logic [IDX_W-1:0] svcIdx,
  output logic             svcAck,
  output logic             svcErr,
  output logic [KEY_W-1:0] svcData,
  output logic             keyAllZero
);

  localparam logic [OTP_W-1:0] PEND_MASK = OTP_W'(1) << PEND_BIT;

  logic [OTP_W-1:0] otpReg;
  logic [KEY_W-1:0] keyBank [NUM_KEYS];
  logic [IDX_W-1:0] clrIdxLocal;

  assign clrIdxLocal = strobe.clrIdx[IDX_W-1:0];

  // set-only word: bits are added, never removed, except by the blank reset
  always_ff @(posedge clk or negedge blankRstN) begin
    if (!blankRstN) begin
      otpReg <= '0;
    end else begin
      otpReg <= otpReg
              | (otpWrEn ? (otpWrData & ~PEND_MASK) : '0)
              | (strobe.setPending ? PEND_MASK : '0);
    end
  end

  assign otpWord = otpReg;

  // one register word per key; clear strobe has priority over a write
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    always_ff @(posedge clk or negedge blankRstN) begin
      if (!blankRstN) begin
        keyBank[k] <= '0;
      end else if (strobe.clrEn && (clrIdxLocal == IDX_W'(k))) begin
        keyBank[k] <= '0;
      end else if (strobe.grant && keyWrEn && (keyWrIdx == IDX_W'(k))) begin
        keyBank[k] <= keyWrData;
      end
    end
  end

  always_comb begin
    keyAllZero = 1'b1;
    for (int k = 0; k < NUM_KEYS; k++) begin
      if (keyBank[k] != '0) keyAllZero = 1'b0;
    end
  end

  // registered service response, data gated at the source
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      svcAck  <= 1'b0;
      svcErr  <= 1'b0;
      svcData <= '0;
    end else begin
      svcAck  <= svcReq;
      svcErr  <= svcReq && !strobe.grant;
      svcData <= (svcReq && strobe.grant) ? keyBank[svcIdx] : '0;
    end
  end

endmodule

// File: rtl/lcs_ctrl.sv
module lcs_ctrl
  import lcs_pkg::*;
#(
  parameter int NUM_KEYS = 8,
  parameter int OTP_W    = 8,
  parameter int FLAG_BIT = 0,
  parameter int PEND_BIT = 1,
  localparam int IDX_W   = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1,
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_KEYS - 1)
) (
  input  logic             clk,
  input  logic             porRstN,
  input  logic [OTP_W-1:0] otpWord,
  input  logic             rmaReq,
  output ctrlStrobe_t      strobe,
  output logic [1:0]       lcState,
  output logic             rmaAvail,
  output logic             rmaRejected,
  output logic             operable,
  output logic             zeroDone
);

  seqFsm_t          fsm;
  lcState_t         lcReg;
  logic [IDX_W-1:0] clrIdx;
  logic             acceptReq;

  assign acceptReq = (fsm == FSM_RUN) && rmaReq && (lcReg == LC_SECURE) && rmaAvail;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      fsm         <= FSM_BOOT;
      lcReg       <= LC_BOOT;
      rmaAvail    <= 1'b0;
      rmaRejected <= 1'b0;
      zeroDone    <= 1'b0;
      clrIdx      <= '0;
    end else begin
      if (rmaReq && !acceptReq) rmaRejected <= 1'b1;
      unique case (fsm)
        FSM_BOOT: begin
          if (otpWord[PEND_BIT]) begin
            fsm    <= FSM_ZERO;
            lcReg  <= LC_RMA;
            clrIdx <= '0;
          end else begin
            fsm      <= FSM_RUN;
            lcReg    <= LC_SECURE;
            rmaAvail <= otpWord[FLAG_BIT];
          end
        end
        FSM_RUN: begin
          if (acceptReq) lcReg <= LC_PEND;
        end
        FSM_ZERO: begin
          if (clrIdx == LAST_IDX) begin
            fsm      <= FSM_DEAD;
            zeroDone <= 1'b1;
          end else begin
            clrIdx <= clrIdx + 1'b1;
          end
        end
        FSM_DEAD: begin
          fsm <= FSM_DEAD;
        end
        default: fsm <= FSM_BOOT;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.setPending = acceptReq;
    strobe.clrEn      = (fsm == FSM_ZERO);
    strobe.clrIdx     = 8'(clrIdx);
    strobe.grant      = (fsm == FSM_RUN);
  end

  assign lcState  = lcReg;
  assign operable = (fsm == FSM_RUN);

endmodule

// File: rtl/lcs_rma_sequencer.sv
module lcs_rma_sequencer
  import lcs_pkg::*;
#(
  parameter int KEY_W    = 32,
  parameter int NUM_KEYS = 8,
  parameter int OTP_W    = 8,
  parameter int FLAG_BIT = 0,
  parameter int PEND_BIT = 1,
  localparam int IDX_W   = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic             clk,
  input  logic             porRstN,
  input  logic             blankRstN,
  input  logic             otpWrEn,
  input  logic [OTP_W-1:0] otpWrData,
  output logic [OTP_W-1:0] otpWord,
  input  logic             rmaReq,
  input  logic             keyWrEn,
  input  logic [IDX_W-1:0] keyWrIdx,
  input  logic [KEY_W-1:0] keyWrData,
  input  logic             svcReq,
  input  logic [IDX_W-1:0] svcIdx,
  output logic             svcAck,
  output logic             svcErr,
  output logic [KEY_W-1:0] svcData,
  output logic [1:0]       lcState,
  output logic             rmaAvail,
  output logic             rmaRejected,
  output logic             operable,
  output logic             zeroDone
);

  ctrlStrobe_t strobe;
  logic        keyAllZero;

  lcs_ctrl #(
    .NUM_KEYS(NUM_KEYS), .OTP_W(OTP_W), .FLAG_BIT(FLAG_BIT), .PEND_BIT(PEND_BIT)
  ) i_ctrl (
    .clk(clk), .porRstN(porRstN), .otpWord(otpWord), .rmaReq(rmaReq),
    .strobe(strobe), .lcState(lcState), .rmaAvail(rmaAvail),
    .rmaRejected(rmaRejected), .operable(operable), .zeroDone(zeroDone)
  );

  lcs_datapath #(
    .KEY_W(KEY_W), .NUM_KEYS(NUM_KEYS), .OTP_W(OTP_W), .PEND_BIT(PEND_BIT)
  ) i_dp (
    .clk(clk), .porRstN(porRstN), .blankRstN(blankRstN), .strobe(strobe),
    .otpWrEn(otpWrEn), .otpWrData(otpWrData), .otpWord(otpWord),
    .keyWrEn(keyWrEn), .keyWrIdx(keyWrIdx), .keyWrData(keyWrData),
    .svcReq(svcReq), .svcIdx(svcIdx), .svcAck(svcAck), .svcErr(svcErr),
    .svcData(svcData), .keyAllZero(keyAllZero)
  );

endmodule

// File: rtl/lcs_rma_checker.sv
module lcs_rma_checker #(
  parameter int OTP_W    = 8,
  parameter int PEND_BIT = 1,
  parameter int KEY_W    = 32
) (
  input logic             clk,
  input logic             porRstN,
  input logic             blankRstN,
  input logic [OTP_W-1:0] otpWord,
  input logic             rmaReq,
  input logic [1:0]       lcState,
  input logic             rmaAvail,
  input logic             rmaRejected,
  input logic             operable,
  input logic             zeroDone,
  input logic             svcAck,
  input logic             svcErr,
  input logic [KEY_W-1:0] svcData,
  input logic             keyAllZero
);

  p_pend_sticky_r2: assert property (@(posedge clk) disable iff (!blankRstN)
    otpWord[PEND_BIT] |=> otpWord[PEND_BIT]);

  p_rise_secure_r3: assert property (@(posedge clk) disable iff (!porRstN || !blankRstN)
    $rose(operable) |-> lcState == 2'b01);

  p_accept_r4: assert property (@(posedge clk) disable iff (!porRstN || !blankRstN)
    (operable && lcState == 2'b01 && rmaAvail && rmaReq) |=> (lcState == 2'b10 && otpWord[PEND_BIT]));

  p_reject_sticky_r5: assert property (@(posedge clk) disable iff (!porRstN || !blankRstN)
    rmaRejected |=> rmaRejected);

  p_zero_clean_r6: assert property (@(posedge clk) disable iff (!porRstN || !blankRstN)
    zeroDone |-> keyAllZero);

  p_rma_dead_r6: assert property (@(posedge clk) disable iff (!porRstN || !blankRstN)
    lcState == 2'b11 |-> !operable);

  p_err_nodata_r8: assert property (@(posedge clk) disable iff (!porRstN || !blankRstN)
    (svcAck && svcErr) |-> svcData == '0);

endmodule

bind lcs_rma_sequencer lcs_rma_checker #(
  .OTP_W(OTP_W), .PEND_BIT(PEND_BIT), .KEY_W(KEY_W)
) i_chk (
  .clk(clk), .porRstN(porRstN), .blankRstN(blankRstN), .otpWord(otpWord),
  .rmaReq(rmaReq), .lcState(lcState), .rmaAvail(rmaAvail),
  .rmaRejected(rmaRejected), .operable(operable), .zeroDone(zeroDone),
  .svcAck(svcAck), .svcErr(svcErr), .svcData(svcData), .keyAllZero(keyAllZero)
);

// File: tb/test_lcs_rma_sequencer.sv
module test_lcs_rma_sequencer;

  localparam int KEY_W = 32;
  localparam int NK    = 8;
  localparam int OW    = 8;
  localparam int IW    = 3;

  logic clk = 1'b0;
  logic porRstN = 1'b0, blankRstN = 1'b0;
  logic otpWrEn = 1'b0;
  logic [OW-1:0] otpWrData = '0;
  logic [OW-1:0] otpWord;
  logic rmaReq = 1'b0, keyWrEn = 1'b0, svcReq = 1'b0;
  logic [IW-1:0] keyWrIdx = '0, svcIdx = '0;
  logic [KEY_W-1:0] keyWrData = '0, svcData;
  logic svcAck, svcErr, rmaAvail, rmaRejected, operable, zeroDone;
  logic [1:0] lcState;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lcs_rma_sequencer i_lcs_rma_sequencer (
    .clk(clk), .porRstN(porRstN), .blankRstN(blankRstN), .otpWrEn(otpWrEn),
    .otpWrData(otpWrData), .otpWord(otpWord), .rmaReq(rmaReq),
    .keyWrEn(keyWrEn), .keyWrIdx(keyWrIdx), .keyWrData(keyWrData),
    .svcReq(svcReq), .svcIdx(svcIdx), .svcAck(svcAck), .svcErr(svcErr),
    .svcData(svcData), .lcState(lcState), .rmaAvail(rmaAvail),
    .rmaRejected(rmaRejected), .operable(operable), .zeroDone(zeroDone)
  );

  function automatic logic [KEY_W-1:0] pat(int i);
    return 32'hA500_0001 + 32'(i) * 32'h0001_0203;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic porPulse();
    porRstN = 1'b0;
    step(2);
    chk(lcState == 2'b00, "R1 state", 64'(lcState), 0);
    chk({operable, rmaAvail, rmaRejected, zeroDone, svcAck} == 5'b0, "R1 flags",
        64'({operable, rmaAvail, rmaRejected, zeroDone, svcAck}), 0);
    porRstN = 1'b1;
    step(1);
  endtask

  task automatic svcRead(int i, bit expErr, logic [KEY_W-1:0] expData, string req);
    svcReq = 1'b1; svcIdx = IW'(i);
    step(1);
    svcReq = 1'b0;
    chk(svcAck && svcErr == expErr && svcData == expData, req,
        64'({svcAck, svcErr, svcData}), 64'({1'b1, expErr, expData}));
  endtask

  task automatic pulseReq();
    rmaReq = 1'b1;
    step(1);
    rmaReq = 1'b0;
  endtask

  initial begin
    step(2);
    chk(lcState == 2'b00 && !operable, "R1 initial", 64'({lcState, operable}), 0);
    blankRstN = 1'b1;
    step(1);
    porRstN = 1'b1;
    step(1);
    // R3: first boot, flag clear
    chk(lcState == 2'b01 && operable, "R3 secure", 64'({lcState, operable}), 64'(3'b011));
    chk(!rmaAvail, "R3 avail clear", 64'(rmaAvail), 0);

    // R7: fill and read back every key word
    for (int i = 0; i < NK; i++) begin
      keyWrEn = 1'b1; keyWrIdx = IW'(i); keyWrData = pat(i);
      step(1);
    end
    keyWrEn = 1'b0;
    for (int i = 0; i < NK; i++) svcRead(i, 1'b0, pat(i), "R7 read");

    // R5: request with flag clear
    pulseReq();
    chk(lcState == 2'b01 && rmaRejected, "R5 refused", 64'({lcState, rmaRejected}), 64'(3'b011));
    step(3);
    chk(rmaRejected, "R5 sticky", 64'(rmaRejected), 1);

    // R2: write all ones, pending bit masked; a zero write clears nothing
    otpWrEn = 1'b1; otpWrData = 8'hFF;
    step(1);
    otpWrData = 8'h00;
    step(1);
    otpWrEn = 1'b0;
    chk(otpWord == 8'hFD, "R2 set-only", 64'(otpWord), 64'(8'hFD));
    chk(!rmaAvail, "R3 avail latched at boot", 64'(rmaAvail), 0);

    // R9 / R3: reboot keeps keys and word; flag now visible
    porPulse();
    chk(lcState == 2'b01 && rmaAvail && !rmaRejected, "R3 avail set",
        64'({lcState, rmaAvail, rmaRejected}), 64'(4'b0110));
    chk(otpWord == 8'hFD, "R9 word kept", 64'(otpWord), 64'(8'hFD));
    for (int i = 0; i < NK; i++) svcRead(i, 1'b0, pat(i), "R9 key kept");

    // R4: accepted request
    pulseReq();
    chk(lcState == 2'b10 && otpWord == 8'hFF && operable && !rmaRejected, "R4 pending",
        64'({lcState, otpWord, operable, rmaRejected}), 64'({2'b10, 8'hFF, 2'b10}));
    // R5: repeat request in pending refused
    pulseReq();
    chk(lcState == 2'b10 && rmaRejected, "R5 pending refused",
        64'({lcState, rmaRejected}), 64'(3'b101));
    svcRead(3, 1'b0, pat(3), "R7 read in pending");

    // R6: second reset runs zeroization
    porPulse();
    chk(lcState == 2'b11 && !operable && !zeroDone, "R6 enter rma",
        64'({lcState, operable, zeroDone}), 64'(4'b1100));
    step(NK - 1);
    chk(!zeroDone, "R6 not yet done", 64'(zeroDone), 0);
    step(1);
    chk(zeroDone && lcState == 2'b11 && !operable, "R6 done",
        64'({zeroDone, lcState, operable}), 64'(4'b1110));

    // R8: service refused, writes ignored, request refused
    svcRead(2, 1'b1, '0, "R8 error response");
    keyWrEn = 1'b1; keyWrIdx = 3'd5; keyWrData = 32'h1234_5678;
    step(1);
    keyWrEn = 1'b0;
    svcRead(5, 1'b1, '0, "R8 write ignored");
    pulseReq();
    chk(lcState == 2'b11 && rmaRejected, "R5 refused in rma",
        64'({lcState, rmaRejected}), 64'(3'b111));

    // R6: every later boot stays terminal
    porPulse();
    chk(lcState == 2'b11 && !operable, "R6 stays rma", 64'({lcState, operable}), 64'(3'b110));
    step(NK);
    chk(zeroDone, "R6 rerun done", 64'(zeroDone), 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule